// File: doc/BRIEF.md
# Channel Status Transmit Sequencer

This block supplies the channel-status bit that a digital audio transmitter places in every frame. The 192-bit status block is held by the host in six 32-bit words. The first word carries block bits 0 to 31, the second carries bits 32 to 63, and so on up to the sixth word. The sequencer copies one word at a time into an internal shift register and hands the frame builder one bit for each frame. Inside each word the bits go out least significant bit first.

A block starts on the strobe that marks the frame carrying the block-start preamble. Each frame-end strobe then advances the block by one bit. A busy indicator rises when the first word is copied into the shifter. It falls when the last word is copied in, so the host knows it may rewrite the words for the next block. Framing, preambles, parity and line coding belong to the surrounding transmitter.

Top module: `cs_tx_sequencer`

## Requirements
- R1: Right after reset, `busy` is 0 and `cs_bit` is 0.
- R2: A `block_start` pulse seen while `tx_en` and `cs_en` are both 1 copies the first word (`cs_words[31:0]`) into the shifter. In the following cycle `busy` is 1 and `cs_bit` equals bit 0 of that word.
- R3: Each `frame_end` pulse advances one bit. After k pulses since the start, `cs_bit` equals block bit k, which is bit k mod 32 of word k/32. Word n sits at `cs_words[32n+31:32n]`.
- R4: `busy` stays 1 through the first 159 frame ends. It drops on the 160th, which copies the sixth word into the shifter, and the sixth word's 32 bits are still sent after that.
- R5: The 192nd frame end ends the block. `cs_bit` then reads 0, and further `frame_end` pulses change nothing until the next accepted `block_start`.
- R6: `block_start` is ignored while either enable is 0, and `busy` stays 0.
- R7: While `cs_en` is 0, `cs_bit` is 0 in the same cycle, whatever the shifter holds.
- R8: Once either enable is 0, `busy` and the current bit are held until the next `frame_end`. That pulse stops the block: `busy` becomes 0 and `cs_bit` reads 0.
- R9: A change to `cs_words` during a block leaves the shifter contents alone. It shows up only when the changed word is next copied into the shifter.
- R10: An accepted `block_start` during a block restarts the block at bit 0 of the first word, even when `frame_end` is pulsed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| cs_en | input | 1 | Channel-status transmission enable |
| frame_end | input | 1 | One-cycle strobe at the end of each frame |
| block_start | input | 1 | One-cycle strobe for the frame carrying the block-start preamble |
| cs_words | input | 192 | Six 32-bit status words, first word in the low bits |
| cs_bit | output | 1 | Channel-status bit for the current frame |
| busy | output | 1 | High from the copy of the first word until the copy of the last word |

## Verification
The hardest state to reach is the boundary where the sixth word is copied into the shifter. There `busy` must fall while the block keeps going for 32 more frames. Stopping one frame early or one frame late there is easy to get wrong. The stimulus reaches this boundary by running complete 192-frame blocks for each entry of a pattern table. Every bit and the busy flag are compared at every frame. Directed runs then cut blocks short: they clear an enable part-way through, restart with a block start that coincides with a frame end, and rewrite the words while a block is running.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  localparam int unsigned CS_WORD_W    = 32;
  localparam int unsigned CS_NUM_WORDS = 6;

  // Shifter command issued by the controller each cycle.
  typedef struct packed {
    logic load;
    logic shift;
  } shift_cmd_t;
endpackage

// File: rtl/cs_word_select.sv
module cs_word_select #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 6,
  localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic [NUM_WORDS*WORD_W-1:0] words_flat,
  input  logic [IDX_W-1:0]            sel,
  output logic [WORD_W-1:0]           word
);
  logic [WORD_W-1:0] slot [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slot
    assign slot[g] = words_flat[g*WORD_W +: WORD_W];
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (sel == IDX_W'(i)) word = slot[i];
    end
  end
endmodule

// File: rtl/cs_bit_shifter.sv
module cs_bit_shifter
  import cs_seq_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shift_cmd_t        cmd,
  input  logic [WORD_W-1:0] load_word,
  output logic              lsb
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              sh_en;

  always_comb begin
    sh_en = cmd.load | cmd.shift;
    sh_d  = sh_q;
    if (cmd.load)       sh_d = load_word;
    else if (cmd.shift) sh_d = {1'b0, sh_q[WORD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign lsb = sh_q[0];

  // R3: bits leave least significant first
  a_r3_shift_lsb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.shift && !cmd.load) |=> (sh_q == ($past(sh_q) >> 1)));
  // R9: the word in force at copy time is captured
  a_r9_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.load |=> (sh_q == $past(load_word)));
  // R9: without a command the held word is untouched by host writes
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.load && !cmd.shift) |=> $stable(sh_q));
endmodule

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl
  import cs_seq_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 6,
  localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned BIT_W    = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             cs_en,
  input  logic             frame_end,
  input  logic             block_start,
  output shift_cmd_t       cmd,
  output logic [IDX_W-1:0] sel,
  output logic             running,
  output logic             busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [IDX_W-1:0] idx_q, idx_d, idx_inc;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             run_q, run_d;
  logic             busy_q, busy_d;
  logic             active, start, stop, adv, upd;

  always_comb begin
    active  = tx_en & cs_en;
    start   = block_start & active;
    stop    = frame_end & ~active;
    adv     = frame_end & active & run_q;
    upd     = start | stop | adv;
    idx_inc = idx_q + IDX_W'(1);

    idx_d     = idx_q;
    bit_d     = bit_q;
    run_d     = run_q;
    busy_d    = busy_q;
    cmd       = '0;
    sel       = idx_inc;

    if (start) begin
      run_d    = 1'b1;
      busy_d   = 1'b1;
      idx_d    = '0;
      bit_d    = '0;
      cmd.load = 1'b1;
      sel      = '0;
    end else if (stop) begin
      run_d  = 1'b0;
      busy_d = 1'b0;
    end else if (adv) begin
      if (bit_q == LAST_BIT) begin
        bit_d = '0;
        if (idx_q == LAST_IDX) begin
          run_d = 1'b0;
        end else begin
          idx_d    = idx_inc;
          cmd.load = 1'b1;
          if (idx_inc == LAST_IDX) busy_d = 1'b0;
        end
      end else begin
        bit_d     = bit_q + BIT_W'(1);
        cmd.shift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      bit_q  <= '0;
      run_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (upd) begin
      idx_q  <= idx_d;
      bit_q  <= bit_d;
      run_q  <= run_d;
      busy_q <= busy_d;
    end
  end

  assign running = run_q;
  assign busy    = busy_q;

  // R2 and R10: an accepted start always lands on word 0, bit 0
  a_r2_start_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    (block_start && tx_en && cs_en) |=> (busy_q && run_q && idx_q == '0 && bit_q == '0));
  // R8: a frame end with an enable low ends the block
  a_r8_stop_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !(tx_en && cs_en)) |=> (!busy_q && !run_q));
  // R4: busy only inside a running block
  a_r4_busy_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> run_q);
  // R4: busy falls only when the last word was copied or the block stopped
  a_r4_busy_fall_point: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (idx_q == LAST_IDX || !run_q));
  // R5: idle persists until an accepted start
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(block_start && tx_en && cs_en)) |=> !run_q);
  // R3: load and shift never coincide
  a_r3_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.load |-> !cmd.shift);
endmodule

// File: rtl/cs_tx_sequencer.sv
module cs_tx_sequencer
  import cs_seq_pkg::*;
#(
  parameter int unsigned WORD_W    = CS_WORD_W,
  parameter int unsigned NUM_WORDS = CS_NUM_WORDS,
  localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned BLOCK_W  = NUM_WORDS * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic               cs_en,
  input  logic               frame_end,
  input  logic               block_start,
  input  logic [BLOCK_W-1:0] cs_words,
  output logic               cs_bit,
  output logic               busy
);
  shift_cmd_t        cmd;
  logic [IDX_W-1:0]  sel;
  logic [WORD_W-1:0] word;
  logic              running;
  logic              lsb;

  cs_seq_ctrl #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cs_en(cs_en),
    .frame_end(frame_end), .block_start(block_start),
    .cmd(cmd), .sel(sel), .running(running), .busy(busy)
  );

  cs_word_select #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_sel (
    .words_flat(cs_words), .sel(sel), .word(word)
  );

  cs_bit_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .load_word(word), .lsb(lsb)
  );

  // R7 mute and R5 silence outside a block
  assign cs_bit = cs_en & running & lsb;

  // R1: busy and output quiet while in reset
  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (!busy && !cs_bit);
  end
endmodule

// File: tb/cs_tx_sequencer_tb_top.sv
module cs_tx_sequencer_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         tx_en, cs_en, frame_end, block_start;
  logic [191:0] cs_words;
  logic         cs_bit, busy;
  int           n_run = 0, n_fail = 0;
  bit           done = 1'b0;

  localparam logic [191:0] PATS [3] = '{
    {32'hFFFF_FFFF, 32'h8000_0001, 32'h0000_0000, 32'hAAAA_5555, 32'h1234_5678, 32'hFFFF_FFFF},
    {32'h0F0F_F0F0, 32'hDEAD_BEEF, 32'h0000_0001, 32'h8000_0000, 32'hCAFE_F00D, 32'h0000_0004},
    {32'h5555_5555, 32'h0000_FFFF, 32'hFFFF_0000, 32'h0137_9BDF, 32'h7654_3210, 32'hA5A5_A5A5}
  };

  always #5 clk = ~clk;

  cs_tx_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cs_en(cs_en),
    .frame_end(frame_end), .block_start(block_start),
    .cs_words(cs_words), .cs_bit(cs_bit), .busy(busy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic frame();
    @(negedge clk) frame_end = 1'b1;
    @(negedge clk) frame_end = 1'b0;
  endtask

  task automatic start();
    @(negedge clk) block_start = 1'b1;
    @(negedge clk) block_start = 1'b0;
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) frame();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; cs_en = 1'b0;
    frame_end = 1'b0; block_start = 1'b0; cs_words = '0;
    #1;
    chk("R1 busy in reset", busy, 1'b0);
    chk("R1 bit in reset", cs_bit, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 1'b0);
    chk("R1 bit after reset", cs_bit, 1'b0);

    // Table walk: full blocks, every bit and busy compared (R2 R3 R4 R5)
    tx_en = 1'b1; cs_en = 1'b1;
    for (int p = 0; p < 3; p++) begin
      cs_words = PATS[p];
      start();
      chk("R2 busy on start", busy, 1'b1);
      chk("R2 first bit", cs_bit, PATS[p][0]);
      for (int k = 1; k <= 192; k++) begin
        frame();
        if (k < 192) begin
          chk("R3 block bit", cs_bit, PATS[p][k]);
          chk("R4 busy window", busy, (k < 160) ? 1'b1 : 1'b0);
        end else begin
          chk("R5 bit after block", cs_bit, 1'b0);
          chk("R5 busy after block", busy, 1'b0);
        end
      end
      frame();
      chk("R5 frame after end ignored", cs_bit | busy, 1'b0);
    end

    // R6: start ignored when an enable is low
    cs_words = {192{1'b1}};
    cs_en = 1'b0; start();
    chk("R6 start with cs_en low", busy, 1'b0);
    cs_en = 1'b1; tx_en = 1'b0; start();
    chk("R6 start with tx_en low", busy, 1'b0);
    tx_en = 1'b1;
    frame();
    chk("R6 no bit after ignored start", cs_bit, 1'b0);

    // R7 and R8 via cs_en
    start();
    chk("R2 all-ones first bit", cs_bit, 1'b1);
    @(negedge clk) cs_en = 1'b0;
    #1;
    chk("R7 muted output", cs_bit, 1'b0);
    chk("R8 busy held until frame end", busy, 1'b1);
    frame();
    chk("R8 busy cleared at frame end", busy, 1'b0);
    @(negedge clk) cs_en = 1'b1;
    #1;
    chk("R8 stopped block stays silent", cs_bit, 1'b0);

    // R8 via tx_en
    start(); frames(5);
    @(negedge clk) tx_en = 1'b0;
    #1;
    chk("R8 bit held before frame end", cs_bit, 1'b1);
    chk("R8 busy held tx_en low", busy, 1'b1);
    frame();
    chk("R8 busy cleared tx_en", busy, 1'b0);
    chk("R8 bit cleared tx_en", cs_bit, 1'b0);
    tx_en = 1'b1;

    // R9: host writes take effect at the next copy
    cs_words = '0;
    start();
    chk("R9 old first word", cs_bit, 1'b0);
    @(negedge clk) cs_words = {192{1'b1}};
    #1;
    chk("R9 write not seen by held word", cs_bit, 1'b0);
    frames(31);
    chk("R9 last bit of old word", cs_bit, 1'b0);
    frame();
    chk("R9 new second word used", cs_bit, 1'b1);

    // R10: restart mid block, also with a coincident frame end
    cs_words = PATS[1];
    start(); frames(40);
    chk("R10 mid-block bit", cs_bit, PATS[1][40]);
    start();
    chk("R10 restart first bit", cs_bit, PATS[1][0]);
    frames(3);
    chk("R10 continues from start", cs_bit, PATS[1][3]);
    @(negedge clk) begin block_start = 1'b1; frame_end = 1'b1; end
    @(negedge clk) begin block_start = 1'b0; frame_end = 1'b0; end
    chk("R10 start wins over frame end", cs_bit, PATS[1][0]);
    chk("R10 busy after restart", busy, 1'b1);
    frame();
    chk("R10 bit one after restart", cs_bit, PATS[1][1]);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule